// File: doc/BRIEF.md
# Memory-Based Return Address Stack

This unit handles subroutine call and return for a simple sequential processor. It keeps return addresses in a last-in-first-out list. The list lives in an external single-port synchronous word store. A separate pointer register, local to the unit, holds the number of live entries, so it also names the next free slot.

A call saves the address of the following instruction into the store and redirects fetch to the call target. A return pops the newest saved word and hands it to fetch as the next program counter. Each command takes two cycles because the store has only one port. While a command is in progress, `busy` is high and new strobes are ignored.

Two error cases are handled. A call on a full list and a return on an empty list each leave the pointer and the store untouched, produce no redirect, and set a sticky flag that only reset clears.

Top module: `linkage_stack`

## Requirements
- R1: After reset the list is empty: `busy`, `npc_vld`, `ovf`, `unf` and `mem_en` are all 0, and any flag raised earlier is cleared.
- R2: A call accepted on a list that is not full issues one store write. The write carries the value `cur_pc + 1` to the slot numbered by the pointer. The pointer then grows by one.
- R3: For a call that is not refused, `npc_vld` is high for exactly one cycle, in the second cycle after the accepting edge. In that cycle `npc` equals the `call_tgt` value sampled at the accepting edge.
- R4: A return on a non-empty list first lowers the pointer by one and then reads that slot. In the cycle where `npc_vld` is high, `npc` equals the word that was read.
- R5: Nested calls return in reverse order: the last address saved is the first one given back.
- R6: `busy` is high for exactly the one cycle after an accepting edge. A call or return strobe seen while `busy` is high has no effect.
- R7: With DEPTH entries live (default 1024), a call does not write the store, does not move the pointer and does not assert `npc_vld`. It sets `ovf`, which stays at 1 until reset.
- R8: With the list empty, a return does not access the store, does not move the pointer and does not assert `npc_vld`. It sets `unf`, which stays at 1 until reset.
- R9: When `call_i` and `ret_i` are both high at an accepting edge, the call is performed and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | AW | Address of the current instruction |
| call_tgt | input | AW | Address of the subroutine entry |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| busy | output | 1 | A command is in progress; strobes are ignored |
| npc | output | AW | Next instruction address |
| npc_vld | output | 1 | One-cycle redirect strobe for `npc` |
| ovf | output | 1 | Sticky: a call was refused because the list was full |
| unf | output | 1 | Sticky: a return was refused because the list was empty |
| mem_en | output | 1 | Store access enable |
| mem_we | output | 1 | Store write enable |
| mem_addr | output | $clog2(DEPTH) | Store word address |
| mem_wdata | output | AW | Store write data |
| mem_rdata | input | AW | Store read data, valid the cycle after a read edge |

## Verification
Every command is accepted at a clock edge E0, and the store request is registered at that same edge. `busy` and the store request can therefore be observed in the cycle after E0. The store acts at the next edge, E1, and the redirect strobe with its address appears in the cycle after E1. The bench drives inputs on falling edges and samples outputs at the falling edge that follows E0 and the one that follows E1. A refused command is checked at both of these points. The pointer itself is not visible at the ports, so it is observed through later returns: a write that should have been suppressed shows up as a wrong value when the next return reads the list.

// File: rtl/linkage_stack.sv
module linkage_stack #(
  parameter int AW    = 16,
  parameter int DEPTH = 1024,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] call_tgt,
  input  logic          call_i,
  input  logic          ret_i,
  output logic          busy,
  output logic [AW-1:0] npc,
  output logic          npc_vld,
  output logic          ovf,
  output logic          unf,
  output logic          mem_en,
  output logic          mem_we,
  output logic [IW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata
);

  logic [PW-1:0] ptr;
  logic [AW-1:0] tgt_q;
  logic          ret_q, ok_q;

  wire full   = (ptr == PW'(DEPTH));
  wire empty  = (ptr == '0);
  wire go     = !busy && (call_i || ret_i);

  assign npc = ret_q ? mem_rdata : tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0; busy <= 1'b0; ovf <= 1'b0; unf <= 1'b0;
      npc_vld <= 1'b0; mem_en <= 1'b0; mem_we <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0; tgt_q <= '0;
      ret_q <= 1'b0; ok_q <= 1'b0;
    end else begin
      npc_vld <= 1'b0;
      if (busy) begin
        busy    <= 1'b0;
        mem_en  <= 1'b0;
        mem_we  <= 1'b0;
        npc_vld <= ok_q;
      end else if (call_i) begin
        busy  <= 1'b1;
        ret_q <= 1'b0;
        tgt_q <= call_tgt;
        if (full) begin
          ovf  <= 1'b1;
          ok_q <= 1'b0;
        end else begin
          ok_q      <= 1'b1;
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= ptr[IW-1:0];
          mem_wdata <= cur_pc + AW'(1);
          ptr       <= ptr + PW'(1);
        end
      end else if (ret_i) begin
        busy  <= 1'b1;
        ret_q <= 1'b1;
        if (empty) begin
          unf  <= 1'b1;
          ok_q <= 1'b0;
        end else begin
          ok_q     <= 1'b1;
          mem_en   <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= IW'(ptr - PW'(1));
          ptr      <= ptr - PW'(1);
        end
      end
    end
  end

  p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(DEPTH));

  p_busy_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy ##1 !busy);

  p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    npc_vld |=> !npc_vld);

  p_call_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && call_i && !full) |=> (mem_en && mem_we && mem_wdata == $past(cur_pc) + AW'(1)));

  p_no_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && call_i && full) |=> (!mem_en && $stable(ptr)));

  p_no_rd_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !call_i && empty) |=> (!mem_en && $stable(ptr)));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);

  p_call_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && call_i && ret_i && !full) |=> mem_we);

endmodule

// File: tb/sim_linkage_stack.sv
`timescale 1ns/1ps
module sim_linkage_stack;
  localparam int AW = 16, DEPTH = 1024, IW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cur_pc = 0, call_tgt = 0, npc, mem_wdata;
  logic call_i = 0, ret_i = 0, busy, npc_vld, ovf, unf, mem_en, mem_we;
  logic [IW-1:0] mem_addr;
  logic [AW-1:0] mem_rdata = 0;
  logic [AW-1:0] store [DEPTH];
  logic [AW-1:0] exp_stk [DEPTH];
  int depth = 0, n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  linkage_stack #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk, .rst_n, .cur_pc, .call_tgt, .call_i, .ret_i, .busy, .npc, .npc_vld,
    .ovf, .unf, .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata);

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) store[mem_addr] <= mem_wdata;
      else mem_rdata <= store[mem_addr];
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; call_i = 0; ret_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    depth = 0;
    chk(!busy && !npc_vld && !mem_en, "R1", "idle after reset", {busy, npc_vld, mem_en}, 0);
    chk(!ovf && !unf, "R1", "flags after reset", {ovf, unf}, 0);
  endtask

  task automatic do_call(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input bit also_ret);
    bit will_ok = (depth < DEPTH);
    cur_pc = pc; call_tgt = tgt; call_i = 1; ret_i = also_ret;
    @(negedge clk);
    call_i = 0; ret_i = 0; call_tgt = ~tgt;
    chk(busy == 1, "R6", "busy after call", busy, 1);
    chk(mem_en == will_ok, "R7", "store access on call", mem_en, will_ok);
    @(negedge clk);
    chk(npc_vld == will_ok, "R3", "npc_vld after call", npc_vld, will_ok);
    if (will_ok) begin
      chk(npc == tgt, "R3", "npc = target", npc, tgt);
      chk(store[depth] == pc + 1, "R2", "saved value", store[depth], pc + 1);
      exp_stk[depth] = pc + 1;
      depth++;
    end else begin
      chk(ovf == 1, "R7", "ovf set", ovf, 1);
    end
    chk(busy == 0, "R6", "busy cleared", busy, 0);
  endtask

  task automatic do_ret();
    bit will_ok = (depth > 0);
    ret_i = 1;
    @(negedge clk);
    ret_i = 0;
    chk(busy == 1, "R6", "busy after return", busy, 1);
    chk(mem_en == will_ok, "R8", "store access on return", mem_en, will_ok);
    @(negedge clk);
    chk(npc_vld == will_ok, "R4", "npc_vld after return", npc_vld, will_ok);
    if (will_ok) begin
      depth--;
      chk(npc == exp_stk[depth], "R5", "returned address", npc, exp_stk[depth]);
    end else begin
      chk(unf == 1, "R8", "unf set", unf, 1);
    end
  endtask

  task automatic t_empty_ret();
    do_ret();
    @(negedge clk);
    chk(unf == 1 && !npc_vld, "R8", "unf sticky, no redirect", {unf, npc_vld}, 2'b10);
  endtask

  task automatic t_nested();
    do_call(16'h0010, 16'h0400, 0);
    do_call(16'h0420, 16'h0800, 0);
    do_call(16'h0830, 16'h0c00, 0);
    for (int i = 0; i < 3; i++) do_ret();
    chk(depth == 0 && !unf && !ovf, "R4", "balanced nest", depth, 0);
  endtask

  task automatic t_busy_ignore();
    cur_pc = 16'h0100; call_tgt = 16'h0200; call_i = 1;
    @(negedge clk);
    call_i = 1; ret_i = 1; call_tgt = 16'h0999; cur_pc = 16'h0555;
    chk(busy == 1, "R6", "busy in cycle 1", busy, 1);
    @(negedge clk);
    call_i = 0; ret_i = 0;
    chk(npc_vld && npc == 16'h0200, "R6", "stray strobes ignored", npc, 16'h0200);
    exp_stk[depth] = 16'h0101; depth++;
    @(negedge clk);
    chk(!busy && !npc_vld, "R6", "no extra command", {busy, npc_vld}, 0);
    do_ret();
    do_ret();
    do_reset();
  endtask

  task automatic t_priority();
    do_call(16'h0040, 16'h0a00, 0);
    do_call(16'h0050, 16'h0b00, 1);
    chk(depth == 2, "R9", "call won over return", depth, 2);
    do_ret();
    do_ret();
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) do_call(AW'(i), AW'(i + 7), 0);
    chk(!ovf, "R7", "no ovf at exactly full", ovf, 0);
    do_call(16'h7777, 16'h1234, 0);
    @(negedge clk);
    chk(ovf && !npc_vld, "R7", "ovf sticky, no redirect", {ovf, npc_vld}, 2'b10);
    do_ret();
    chk(npc == AW'(DEPTH), "R7", "top entry intact", npc, DEPTH);
    do_reset();
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_empty_ret();
    do_reset();
    t_nested();
    t_busy_ignore();
    t_priority();
    t_full();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule